// File: doc/BRIEF.md
# Priority-Aware Bus Request Gate

This block sits in the symmetric agent of a shared system bus on which one other agent holds higher priority. Transaction requests arrive from a local queue with a valid signal and a tag. The block decides in each cycle whether the pending request may be issued. It drives the agent's own active-low bus request line. It also contains a model of the high-priority agent. That model counts the priority agent's outstanding requests and drives the active-low priority line.

While the priority line is seen asserted, new requests from the symmetric agent are held back. The exception is a locked sequence that is already open: its remaining requests keep flowing, so the sequence can finish while priority is held. The priority agent keeps its line asserted until every one of its requests has completed. It releases the line one cycle after its outstanding count returns to zero. A blocked request waits with its valid signal held. It is issued unchanged in the first cycle in which the gate allows it.

Top module: `busPriorityGate`

## Requirements
- R1: After reset, symReqN and prioN are 1, issueValid is 0, prioReady is 1, and reqReady is 1.
- R2: symReqN is 0 in the cycle after a cycle with reqValid high, and 1 in the cycle after a cycle with reqValid low.
- R3: A priority request (prioNew high while prioReady is 1) drives prioN to 0 from the next cycle. prioN stays 0 while any priority request is outstanding.
- R4: When the last outstanding priority request completes, prioN stays 0 for one more cycle and then returns to 1, provided no new priority request arrives in that cycle.
- R5: The gate uses prioN as sampled at the previous clock edge. reqReady is 1 when that sampled value is 1 or a locked sequence is open, and 0 otherwise.
- R6: A request issued with reqLockBegin=1 and reqLockEnd=0 opens a locked sequence. A request issued with reqLockEnd=1 closes it. While the sequence is open, requests are allowed regardless of priority. The opening request itself is gated like any other request.
- R7: A request is issued in a cycle where reqValid and reqReady are both 1. In the next cycle issueValid is 1 and issueTag equals the reqTag that was issued. Otherwise issueValid is 0 in the next cycle.
- R8: The outstanding priority count saturates at 2**CNT_W-1. prioReady is 0 at that count, and a prioNew in that state is dropped, so it needs no completion.
- R9: A prioDone arriving when no priority request is outstanding is ignored. It neither drives the count below zero nor shortens a later priority hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bus clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Local queue has a request pending |
| reqTag | input | TAG_W | Tag of the pending request |
| reqLockBegin | input | 1 | Pending request opens a locked sequence |
| reqLockEnd | input | 1 | Pending request closes a locked sequence |
| reqReady | output | 1 | Pending request may be issued this cycle |
| issueValid | output | 1 | A request was issued in the previous cycle |
| issueTag | output | TAG_W | Tag of the request issued in the previous cycle |
| symReqN | output | 1 | Active-low bus request of the symmetric agent |
| prioNew | input | 1 | Priority agent issues a new request |
| prioDone | input | 1 | One priority request completes |
| prioReady | output | 1 | Priority agent may take a new request (count not full) |
| prioN | output | 1 | Active-low priority line |

## Verification
The bound checker covers the relations that hold on every cycle. These are the bus request line following reqValid by one cycle, and the priority line dropping after an accepted priority request. They also include the gate closing one cycle after the line is seen low unless a lock is open, the issued tag echoing the accepted one, and a count that neither wraps at the top nor rises on a dropped request. Other behaviour shows only across a scenario, so the bench's directed and random runs cover it. That includes the exact release cycle after the final completion and a lock sequence that opens before priority and closes under it. It also includes a request held for many cycles and issued unchanged, saturation followed by a drain that needs exactly the accepted number of completions, and stray completions that must leave the hold length untouched.

// File: rtl/busGatePkg.sv
package busGatePkg;

  // Strobes from control to datapath, one cycle's worth of decisions.
  typedef struct packed {
    logic issueFire;   // pending symmetric request is issued now
    logic cntInc;      // priority request accepted
    logic cntDec;      // priority request completed (count nonzero)
  } gateStrobes_t;

endpackage

// File: rtl/busGateCtrl.sv
module busGateCtrl
  import busGatePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqLockBegin,
  input  logic         reqLockEnd,
  input  logic         prioNew,
  input  logic         prioDone,
  input  logic         cntZero,
  input  logic         cntFull,
  output logic         reqReady,
  output logic         symReqN,
  output logic         prioN,
  output logic         prioReady,
  output logic         lockOpen,
  output gateStrobes_t strobes
);

  logic prioNQ;
  logic prioSeenNQ;
  logic symReqNQ;
  logic lockOpenQ;
  logic allowed;
  logic fire;
  logic incOk;
  logic decOk;
  logic lockOpenNext;
  logic prioNNext;

  // Gate decision uses only registered state, so reqReady never
  // depends combinationally on the request inputs.
  always_comb begin
    allowed = prioSeenNQ | lockOpenQ;
    fire    = reqValid & allowed;
    incOk   = prioNew & ~cntFull;
    decOk   = prioDone & ~cntZero;
  end

  // Lock flag: the opening request sets it, the closing one clears it.
  always_comb begin
    lockOpenNext = lockOpenQ;
    if (fire) begin
      if (reqLockEnd) begin
        lockOpenNext = 1'b0;
      end else if (reqLockBegin) begin
        lockOpenNext = 1'b1;
      end
    end
  end

  // Priority line stays low while the registered count is nonzero or a
  // new request is accepted; it rises the edge after the count hits zero.
  always_comb begin
    prioNNext = ~(~cntZero | incOk);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioNQ     <= 1'b1;
      prioSeenNQ <= 1'b1;
      symReqNQ   <= 1'b1;
      lockOpenQ  <= 1'b0;
    end else begin
      prioNQ     <= prioNNext;
      prioSeenNQ <= prioNQ;
      symReqNQ   <= ~reqValid;
      lockOpenQ  <= lockOpenNext;
    end
  end

  always_comb begin
    reqReady          = allowed;
    symReqN           = symReqNQ;
    prioN             = prioNQ;
    prioReady         = ~cntFull;
    lockOpen          = lockOpenQ;
    strobes.issueFire = fire;
    strobes.cntInc    = incOk;
    strobes.cntDec    = decOk;
  end

endmodule

// File: rtl/busGateDatapath.sv
module busGateDatapath
  import busGatePkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateStrobes_t     strobes,
  input  logic [TAG_W-1:0] reqTag,
  output logic             issueValid,
  output logic [TAG_W-1:0] issueTag,
  output logic             cntZero,
  output logic             cntFull,
  output logic [CNT_W-1:0] prioCount
);

  localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic             issueValidQ;
  logic [TAG_W-1:0] issueTagQ;

  always_comb begin
    unique case ({strobes.cntInc, strobes.cntDec})
      2'b10:   cntNext = cntQ + CNT_ONE;
      2'b01:   cntNext = cntQ - CNT_ONE;
      default: cntNext = cntQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ        <= '0;
      issueValidQ <= 1'b0;
      issueTagQ   <= '0;
    end else begin
      cntQ        <= cntNext;
      issueValidQ <= strobes.issueFire;
      if (strobes.issueFire) begin
        issueTagQ <= reqTag;
      end
    end
  end

  always_comb begin
    cntZero    = (cntQ == '0);
    cntFull    = (cntQ == CNT_TOP);
    issueValid = issueValidQ;
    issueTag   = issueTagQ;
    prioCount  = cntQ;
  end

endmodule

// File: rtl/busPriorityGate.sv
module busPriorityGate
  import busGatePkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [TAG_W-1:0] reqTag,
  input  logic             reqLockBegin,
  input  logic             reqLockEnd,
  output logic             reqReady,
  output logic             issueValid,
  output logic [TAG_W-1:0] issueTag,
  output logic             symReqN,
  input  logic             prioNew,
  input  logic             prioDone,
  output logic             prioReady,
  output logic             prioN
);

  gateStrobes_t     strobes;
  logic             cntZero;
  logic             cntFull;
  logic             lockOpen;
  logic [CNT_W-1:0] prioCount;

  busGateCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqLockBegin (reqLockBegin),
    .reqLockEnd   (reqLockEnd),
    .prioNew      (prioNew),
    .prioDone     (prioDone),
    .cntZero      (cntZero),
    .cntFull      (cntFull),
    .reqReady     (reqReady),
    .symReqN      (symReqN),
    .prioN        (prioN),
    .prioReady    (prioReady),
    .lockOpen     (lockOpen),
    .strobes      (strobes)
  );

  busGateDatapath #(
    .TAG_W (TAG_W),
    .CNT_W (CNT_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqTag     (reqTag),
    .issueValid (issueValid),
    .issueTag   (issueTag),
    .cntZero    (cntZero),
    .cntFull    (cntFull),
    .prioCount  (prioCount)
  );

endmodule

// File: rtl/busPriorityGateChecker.sv
module busPriorityGateChecker #(
  parameter int TAG_W = 8,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [TAG_W-1:0] reqTag,
  input logic             reqReady,
  input logic             issueValid,
  input logic [TAG_W-1:0] issueTag,
  input logic             symReqN,
  input logic             prioNew,
  input logic             prioDone,
  input logic             prioReady,
  input logic             prioN,
  input logic             lockOpen,
  input logic [CNT_W-1:0] prioCount
);

  assert_symreq_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !symReqN);

  assert_symreq_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> symReqN);

  assert_prio_take_R3: assert property (@(posedge clk) disable iff (!rstN)
    (prioNew && prioReady) |=> !prioN);

  assert_prio_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(prioN) |-> ($past(prioCount) == '0));

  assert_gate_closed_R5: assert property (@(posedge clk) disable iff (!rstN)
    !prioN |=> (reqReady == lockOpen));

  assert_gate_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    prioN |=> reqReady);

  assert_issue_echo_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (issueValid && issueTag == $past(reqTag)));

  assert_no_issue_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !issueValid);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (prioNew && !prioReady && !prioDone) |=> $stable(prioCount));

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (prioDone && !prioNew && prioCount == '0) |=> (prioCount == '0));

endmodule

bind busPriorityGate busPriorityGateChecker #(
  .TAG_W (TAG_W),
  .CNT_W (CNT_W)
) uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqTag     (reqTag),
  .reqReady   (reqReady),
  .issueValid (issueValid),
  .issueTag   (issueTag),
  .symReqN    (symReqN),
  .prioNew    (prioNew),
  .prioDone   (prioDone),
  .prioReady  (prioReady),
  .prioN      (prioN),
  .lockOpen   (lockOpen),
  .prioCount  (prioCount)
);

// File: tb/tb_busPriorityGate.sv
module tb_busPriorityGate;

  localparam int TAG_W   = 8;
  localparam int CNT_W   = 3;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [TAG_W-1:0] reqTag = '0;
  logic             reqLockBegin = 1'b0;
  logic             reqLockEnd = 1'b0;
  logic             reqReady;
  logic             issueValid;
  logic [TAG_W-1:0] issueTag;
  logic             symReqN;
  logic             prioNew = 1'b0;
  logic             prioDone = 1'b0;
  logic             prioReady;
  logic             prioN;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  busPriorityGate #(.TAG_W(TAG_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTag(reqTag),
    .reqLockBegin(reqLockBegin), .reqLockEnd(reqLockEnd), .reqReady(reqReady),
    .issueValid(issueValid), .issueTag(issueTag), .symReqN(symReqN),
    .prioNew(prioNew), .prioDone(prioDone), .prioReady(prioReady), .prioN(prioN)
  );

  // Reference model built from the requirements.
  int         mCnt;
  bit         mPrioN, mSeenN, mLock, mSymN, mIssueV, mFired;
  bit [TAG_W-1:0] mTag;

  function automatic bit modelReady(bit seenN, bit lockOpen);
    return seenN | lockOpen;
  endfunction

  function automatic bit modelPrioNext(int cnt, bit accepted);
    return !((cnt != 0) || accepted);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mPrioN = 1; mSeenN = 1; mLock = 0; mSymN = 1;
      mIssueV = 0; mFired = 0; mTag = '0;
    end else begin
      bit fire, acc, dec;
      fire = reqValid && modelReady(mSeenN, mLock);
      acc  = prioNew && (mCnt < CNT_MAX);
      dec  = prioDone && (mCnt != 0);
      mSeenN = mPrioN;
      mPrioN = modelPrioNext(mCnt, acc);
      mCnt   = mCnt + int'(acc) - int'(dec);
      mSymN  = !reqValid;
      if (fire) begin
        if (reqLockEnd) mLock = 0;
        else if (reqLockBegin) mLock = 1;
        mTag = reqTag;
      end
      mIssueV = fire;
      mFired  = fire;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Continuous comparison, away from the active edge.
  bit cmpOn = 0;
  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      check(reqReady == modelReady(mSeenN, mLock), "R5 R6", "reqReady",
            int'(reqReady), int'(modelReady(mSeenN, mLock)));
      check(symReqN == mSymN, "R2", "symReqN", int'(symReqN), int'(mSymN));
      check(prioN == mPrioN, "R3 R4", "prioN", int'(prioN), int'(mPrioN));
      check(prioReady == (mCnt < CNT_MAX), "R8", "prioReady",
            int'(prioReady), int'(mCnt < CNT_MAX));
      check(issueValid == mIssueV, "R7", "issueValid",
            int'(issueValid), int'(mIssueV));
      if (mIssueV)
        check(issueTag == mTag, "R7", "issueTag", int'(issueTag), int'(mTag));
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    reqValid = 0; reqLockBegin = 0; reqLockEnd = 0; prioNew = 0; prioDone = 0;
  endtask

  // Watchdog.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(symReqN == 1, "R1", "symReqN", int'(symReqN), 1);
    check(prioN == 1, "R1", "prioN", int'(prioN), 1);
    check(issueValid == 0, "R1", "issueValid", int'(issueValid), 0);
    check(prioReady == 1, "R1", "prioReady", int'(prioReady), 1);
    check(reqReady == 1, "R1", "reqReady", int'(reqReady), 1);
    cmpOn = 1;

    // R3/R5/R4 directed timing
    prioNew = 1; tick(); prioNew = 0;
    check(prioN == 0, "R3", "prioN after accept", int'(prioN), 0);
    check(reqReady == 1, "R5", "reqReady before sample", int'(reqReady), 1);
    tick();
    check(reqReady == 0, "R5", "reqReady after sample", int'(reqReady), 0);
    reqValid = 1; reqTag = 8'hA5;
    repeat (4) begin
      tick();
      check(issueValid == 0, "R7", "held request not issued", int'(issueValid), 0);
    end
    prioDone = 1; tick(); prioDone = 0;
    check(prioN == 0, "R4", "prioN one cycle after zero", int'(prioN), 0);
    tick();
    check(prioN == 1, "R4", "prioN released", int'(prioN), 1);
    tick();
    check(reqReady == 1, "R5", "reqReady reopened", int'(reqReady), 1);
    tick();
    check(issueValid == 1 && issueTag == 8'hA5, "R7", "held tag issued",
          int'(issueTag), 8'hA5);
    idle(); tick();

    // R6 lock sequence opening before priority, closing under it
    reqValid = 1; reqLockBegin = 1; reqTag = 8'h11; tick();
    reqLockBegin = 0; reqValid = 0; prioNew = 1; tick(); prioNew = 0; tick();
    check(reqReady == 1, "R6", "open lock bypasses priority", int'(reqReady), 1);
    reqValid = 1; reqTag = 8'h12; tick();
    check(issueValid == 1 && issueTag == 8'h12, "R6", "locked request issued",
          int'(issueTag), 8'h12);
    reqTag = 8'h13; reqLockEnd = 1; tick();
    check(issueValid == 1 && issueTag == 8'h13, "R6", "closing request issued",
          int'(issueTag), 8'h13);
    reqLockEnd = 0; reqTag = 8'h14; tick();
    check(reqReady == 0 && issueValid == 0, "R6", "gate closed after lock end",
          int'(reqReady), 0);
    // opening request under priority is gated
    reqLockBegin = 1; tick();
    check(issueValid == 0, "R6", "lock opener gated", int'(issueValid), 0);
    idle(); prioDone = 1; tick(); prioDone = 0; repeat (3) tick();

    // R8 saturation then drain
    prioNew = 1;
    repeat (CNT_MAX + 2) tick();
    check(prioReady == 0, "R8", "prioReady at max", int'(prioReady), 0);
    prioNew = 0; prioDone = 1;
    repeat (CNT_MAX) tick();
    prioDone = 0;
    check(prioN == 0, "R8", "prioN hold after drain", int'(prioN), 0);
    tick();
    check(prioN == 1, "R8", "drained after max completions", int'(prioN), 1);

    // R9 stray completions
    prioDone = 1; repeat (3) tick(); prioDone = 0;
    check(prioN == 1, "R9", "stray completion", int'(prioN), 1);
    prioNew = 1; tick(); prioNew = 0; repeat (2) tick();
    check(prioN == 0, "R9", "hold not shortened", int'(prioN), 0);
    prioDone = 1; tick(); prioDone = 0; tick();
    check(prioN == 1, "R9", "single completion releases", int'(prioN), 1);

    // Constrained random phase
    idle();
    for (int i = 0; i < 4000; i++) begin
      if (!(reqValid && !mFired)) begin
        reqValid     = ($urandom % 3) != 0;
        reqTag       = TAG_W'($urandom);
        reqLockBegin = !mLock && (($urandom % 6) == 0);
        reqLockEnd   = mLock && (($urandom % 4) == 0);
      end
      prioNew  = (($urandom % 8) < ((i / 500) % 2 == 0 ? 1 : 4));
      prioDone = ($urandom % 3) == 0;
      tick();
    end
    idle(); tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule